// File: doc/BRIEF.md
# Trigger Routing Selection Cell

This cell chooses one trigger line out of a set of front-panel lines, backplane trigger lines, star trigger lines and an internal one-shot software trigger, and drives a single routed output from it. In pass-through mode the chosen line reaches the output combinationally. In realigned mode the chosen line is sampled on ticks of a synchronization clock and the output changes only on those ticks. An optional shift of whole ticks can then be added, so that routes with short physical paths can be held back to line up with routes that have longer ones.

The synchronization tick comes from the system clock at full rate or from one of two programmable divide-by-N counters, and each route picks one of the three. The realigned output can be presented on the rising clock edge or half a cycle later on the falling edge. The output can be inverted for active-low destinations, or tied low by selecting the ground code. A software request produces one pulse exactly one synchronization period wide. Further requests are dropped while that pulse is pending or active.

Top module: `trig_route_cell`

## Requirements
- R1: `src_sel` picks the source. Codes 0 to 5 are `fp_in[0..5]`, 6 to 13 are `bp_in[0..7]`, 14 to 30 are `star_in[0..16]`, and 31 is the software pulse. In pass-through mode (`sync_mode`=0) the output follows the chosen line within the same cycle.
- R2: When `invert`=1 the routed output is the complement of the value the path would otherwise give. This holds in both modes.
- R3: Any `src_sel` code of 32 or above ties `route_out` low, whatever the values of `invert` and `sync_mode`.
- R4: In realigned mode at full rate with zero delay, a source change is sampled at the next rising edge and appears at `route_out` just after that edge.
- R5: With `fall_edge`=1 the realigned output changes at the falling edge that follows the rising sampling edge, which is half a cycle later than with `fall_edge`=0.
- R6: `rate_sel` selects the tick as follows: 0 or 3 gives every cycle, 1 gives every `div_n` cycles, and 2 gives every `div_m` cycles. A divider value of 0 or 1 means every cycle. A realigned output that has just risen on a tick falls exactly one tick period after its input drops.
- R7: `delay` (0 to 255) adds that many tick periods to the realigned path. For a full-rate route it shows as `delay` extra cycles. For a divided route, the time from output rise to output fall after the input drops is (`delay`+1) tick periods.
- R8: A one-cycle `sw_req` starts a software pulse at the next tick after the request is registered. The pulse stays high for exactly one tick period.
- R9: An `sw_req` that arrives while a software pulse is pending or high is ignored and adds no extra pulse.
- R10: After reset, `route_out` is low when a low source is chosen with no inversion, and the delay line and dividers start from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_in | input | 6 | Front-panel trigger lines |
| bp_in | input | 8 | Backplane trigger lines |
| star_in | input | 17 | Star trigger lines |
| src_sel | input | 6 | Source code (see R1, R3) |
| sync_mode | input | 1 | 1 = realigned, 0 = pass-through |
| rate_sel | input | 2 | Tick source (see R6) |
| div_n | input | 16 | First divider ratio |
| div_m | input | 16 | Second divider ratio |
| fall_edge | input | 1 | Present realigned output on the falling edge |
| invert | input | 1 | Invert routed output |
| delay | input | 8 | Realigned delay in ticks |
| sw_req | input | 1 | Software one-shot request |
| route_out | output | 1 | Routed trigger |

## Verification
Pass-through results are due in the same cycle, so they are sampled 1 ns after the input is driven. Realigned full-rate results are due one rising edge after the change plus `delay` edges. The bench samples 3 ns after each edge and confirms the output is still low on every edge before the due one. Falling-edge results are sampled both at 3 ns (output still low) and at 8 ns (output high), which falls either side of the 5 ns falling edge. The bench cannot know the divider phase, so divided routes are checked by measuring the interval from output rise to output fall, which must be exactly (`delay`+1) tick periods. Software pulses are checked by counting the edges at which the output is high.

// File: rtl/trig_route_pkg.sv
package trig_route_pkg;
   typedef enum logic [1:0] {
      RATE_FULL     = 2'd0,
      RATE_DIV_N    = 2'd1,
      RATE_DIV_M    = 2'd2,
      RATE_FULL_ALT = 2'd3
   } rate_e;
   localparam int NUM_DIVIDERS = 2;
endpackage

// File: rtl/trig_clk_div.sv
module trig_clk_div #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] div_i,
   output logic         tick_o
);
   localparam logic [W-1:0] ONE = W'(1);

   generate
      if (W < 2) begin : g_bad_w
         $error("trig_clk_div: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt;
   logic         bypass;

   assign bypass = (div_i <= ONE);
   assign tick_o = bypass || (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (bypass)              cnt <= '0;
      else if (cnt >= div_i - ONE)  cnt <= '0;
      else                          cnt <= cnt + ONE;
   end

   // R6
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && div_i > ONE) |=> (!tick_o || div_i <= ONE));
endmodule

// File: rtl/trig_sw_pulse.sv
module trig_sw_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic req_i,
   output logic pulse_o
);
   logic pend, act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         act  <= 1'b0;
      end else begin
         if (tick_i && pend) begin
            act  <= 1'b1;
            pend <= 1'b0;
         end else if (tick_i) begin
            act  <= 1'b0;
         end
         if (req_i && !pend && !act) pend <= 1'b1;
      end
   end

   assign pulse_o = act;

   // R8
   one_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && tick_i) |=> !act);
   // R9
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && act) |=> !pend);
endmodule

// File: rtl/trig_sync_path.sv
module trig_sync_path #(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             d_i,
   input  logic [DLY_W-1:0] dly_i,
   input  logic             fall_i,
   output logic             q_o
);
   localparam int DEPTH = 1 << DLY_W;

   generate
      if (DLY_W < 1 || DLY_W > 10) begin : g_bad_dly
         $error("trig_sync_path: DLY_W out of range 1..10");
      end
   endgenerate

   logic [DEPTH-1:0] stages;
   logic             tap;
   logic             fall_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stages <= '0;
      else if (tick_i) stages <= {stages[DEPTH-2:0], d_i};
   end

   assign tap = stages[dly_i];

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) fall_q <= 1'b0;
      else        fall_q <= tap;
   end

   assign q_o = fall_i ? fall_q : tap;

   // R4
   hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> ($stable(tap) || !$stable(dly_i)));
endmodule

// File: rtl/trig_route_cell.sv
module trig_route_cell
   import trig_route_pkg::*;
#(
   parameter int N_FP   = 6,
   parameter int N_BP   = 8,
   parameter int N_STAR = 17,
   parameter int DIV_W  = 16,
   parameter int DLY_W  = 8,
   localparam int N_IN  = N_FP + N_BP + N_STAR,
   localparam int SEL_W = $clog2(N_IN + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_FP-1:0]   fp_in,
   input  logic [N_BP-1:0]   bp_in,
   input  logic [N_STAR-1:0] star_in,
   input  logic [SEL_W-1:0]  src_sel,
   input  logic              sync_mode,
   input  logic [1:0]        rate_sel,
   input  logic [DIV_W-1:0]  div_n,
   input  logic [DIV_W-1:0]  div_m,
   input  logic              fall_edge,
   input  logic              invert,
   input  logic [DLY_W-1:0]  delay,
   input  logic              sw_req,
   output logic              route_out
);
   localparam logic [SEL_W-1:0] GND_SEL = SEL_W'(N_IN + 1);

   generate
      if (N_FP < 1 || N_BP < 1 || N_STAR < 1) begin : g_bad_src
         $error("trig_route_cell: every source group needs at least one line");
      end
   endgenerate

   logic [NUM_DIVIDERS-1:0][DIV_W-1:0] div_vals;
   logic [NUM_DIVIDERS-1:0]            div_ticks;
   logic                               tick;
   logic                               sw_pulse;
   logic [N_IN:0]                      src_vec;
   logic                               is_gnd;
   logic                               sel_bit;
   logic                               sync_q;
   logic                               core;

   assign div_vals = {div_m, div_n};

   generate
      for (genvar g = 0; g < NUM_DIVIDERS; g++) begin : g_div
         trig_clk_div #(.W(DIV_W)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .div_i (div_vals[g]),
            .tick_o(div_ticks[g])
         );
      end
   endgenerate

   always_comb begin
      unique case (rate_e'(rate_sel))
         RATE_DIV_N: tick = div_ticks[0];
         RATE_DIV_M: tick = div_ticks[1];
         default:    tick = 1'b1;
      endcase
   end

   trig_sw_pulse u_sw (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick),
      .req_i  (sw_req),
      .pulse_o(sw_pulse)
   );

   assign src_vec = {sw_pulse, star_in, bp_in, fp_in};
   assign is_gnd  = (src_sel >= GND_SEL);
   assign sel_bit = is_gnd ? 1'b0 : src_vec[src_sel];

   trig_sync_path #(.DLY_W(DLY_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .tick_i(tick),
      .d_i   (sel_bit),
      .dly_i (delay),
      .fall_i(fall_edge),
      .q_o   (sync_q)
   );

   assign core      = sync_mode ? sync_q : sel_bit;
   assign route_out = is_gnd ? 1'b0 : (core ^ invert);

   // R6
   full_rate_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel == 2'd0 || rate_sel == 2'd3) |-> tick);
endmodule

// File: tb/trig_route_cell_bench.sv
module trig_route_cell_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  fp_in = '0;
   logic [7:0]  bp_in = '0;
   logic [16:0] star_in = '0;
   logic [5:0]  src_sel = '0;
   logic        sync_mode = 1'b0;
   logic [1:0]  rate_sel = '0;
   logic [15:0] div_n = 16'd4;
   logic [15:0] div_m = 16'd3;
   logic        fall_edge = 1'b0;
   logic        invert = 1'b0;
   logic [7:0]  delay = '0;
   logic        sw_req = 1'b0;
   logic        route_out;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   trig_route_cell u_trig_route_cell (
      .clk(clk), .rst_n(rst_n), .fp_in(fp_in), .bp_in(bp_in), .star_in(star_in),
      .src_sel(src_sel), .sync_mode(sync_mode), .rate_sel(rate_sel),
      .div_n(div_n), .div_m(div_m), .fall_edge(fall_edge), .invert(invert),
      .delay(delay), .sw_req(sw_req), .route_out(route_out)
   );

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: route_out=%b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_int(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic quiet(int n);
      fp_in = '0; bp_in = '0; star_in = '0;
      repeat (n) @(posedge clk);
   endtask

   // R10
   task automatic t_reset();
      #2 chk("R10 reset output low", route_out, 1'b0);
   endtask

   // R1 R2 R3: pass-through routing
   task automatic t_async();
      sync_mode = 0; invert = 0;
      @(posedge clk); #2;
      fp_in = 6'b111011; src_sel = 6'd2; #1 chk("R1 fp2 low", route_out, 1'b0);
      fp_in = 6'b000100; #1 chk("R1 fp2 high", route_out, 1'b1);
      fp_in = '0; bp_in = 8'h80; src_sel = 6'd13; #1 chk("R1 bp7", route_out, 1'b1);
      src_sel = 6'd6; #1 chk("R1 bp0 low", route_out, 1'b0);
      star_in = 17'h10000; src_sel = 6'd30; #1 chk("R1 star16", route_out, 1'b1);
      src_sel = 6'd14; #1 chk("R1 star0 low", route_out, 1'b0);
      invert = 1; #1 chk("R2 inverted low source", route_out, 1'b1);
      src_sel = 6'd30; #1 chk("R2 inverted high source", route_out, 1'b0);
      src_sel = 6'd32; #1 chk("R3 ground with invert", route_out, 1'b0);
      src_sel = 6'd63; sync_mode = 1; #1 chk("R3 ground code 63 realigned", route_out, 1'b0);
      repeat (3) @(posedge clk); #3 chk("R3 ground realigned held", route_out, 1'b0);
      sync_mode = 0; invert = 0; src_sel = '0;
      quiet(2);
   endtask

   // R4 R5 R7: full-rate realigned path
   task automatic t_sync_full(logic fe, int dly, logic inv);
      string tag;
      tag = fe ? "R5" : (dly > 0 ? "R7" : "R4");
      sync_mode = 1; rate_sel = 2'd0; fall_edge = fe; delay = 8'(dly);
      invert = inv; src_sel = 6'd0;
      quiet(12);
      @(posedge clk); #2 fp_in[0] = 1'b1;
      #1 chk({tag, " before sampling edge"}, route_out, inv);
      for (int i = 0; i < dly; i++) begin
         @(posedge clk); #3 chk({tag, " held by delay"}, route_out, inv);
      end
      @(posedge clk); #3;
      chk({tag, " after rising edge"}, route_out, fe ? inv : ~inv);
      #5 chk({tag, " after falling edge"}, route_out, ~inv);
      fp_in = '0; invert = 0; fall_edge = 0; delay = '0;
   endtask

   // R6 R7: divided tick, rise-to-fall interval
   task automatic t_div(logic [1:0] rs, int ratio, int dly);
      int cnt;
      sync_mode = 1; rate_sel = rs; fall_edge = 0; delay = 8'(dly);
      invert = 0; src_sel = 6'd1;
      quiet(40 + 4 * ratio * (dly + 1));
      @(posedge clk); #2 fp_in[1] = 1'b1;
      cnt = 0;
      do begin @(posedge clk); #3 cnt++; end while (!route_out && cnt < 400);
      checks++;
      if (cnt < 1 || cnt > ratio * (dly + 1)) begin
         fails++;
         $display("FAIL R6 rise latency: got %0d expected 1..%0d", cnt, ratio * (dly + 1));
      end
      fp_in[1] = 1'b0;
      cnt = 0;
      do begin @(posedge clk); #3 cnt++; end while (route_out && cnt < 400);
      chk_int(dly > 0 ? "R7 divided delay interval" : "R6 tick period", cnt, ratio * (dly + 1));
      delay = '0; rate_sel = 2'd0;
   endtask

   // R8 R9: software one-shot
   task automatic t_sw(logic [1:0] rs, int ratio, logic retrig);
      int highs;
      sync_mode = 0; rate_sel = rs; invert = 0; src_sel = 6'd31;
      quiet(10);
      @(posedge clk); #2 sw_req = 1'b1;
      @(posedge clk); #2 sw_req = 1'b0;
      highs = 0;
      for (int i = 0; i < 30; i++) begin
         @(posedge clk); #3;
         if (route_out) begin
            highs++;
            if (retrig && highs == 1) sw_req = 1'b1;
         end else sw_req = 1'b0;
         if (highs > 1) sw_req = 1'b0;
      end
      sw_req = 1'b0;
      chk_int(retrig ? "R9 request during pulse ignored" : "R8 pulse width", highs, ratio);
      rate_sel = 2'd0; src_sel = '0;
   endtask

   initial begin
      #1_000_000;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      t_reset();
      t_async();
      t_sync_full(1'b0, 0, 1'b0);
      t_sync_full(1'b1, 0, 1'b0);
      t_sync_full(1'b0, 3, 1'b0);
      t_sync_full(1'b0, 0, 1'b1);
      t_div(2'd1, 4, 0);
      t_div(2'd2, 3, 0);
      t_div(2'd1, 4, 2);
      t_div(2'd3, 1, 0);
      div_n = 16'd1;
      t_div(2'd1, 1, 0);
      div_n = 16'd4;
      t_sw(2'd0, 1, 1'b0);
      t_sw(2'd1, 4, 1'b0);
      t_sw(2'd1, 4, 1'b1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule